// File: doc/BRIEF.md
# Byte-Oriented SPI Master with Transmit and Receive Queues

This block is an SPI master that software drives through a small 32-bit register window. Software queues outgoing bytes, programs how many bytes an exchange moves, and sets a start bit in the control word. The shift engine then clocks that many bytes out on the serial data line, most significant bit first. It captures one incoming byte for every byte it sends and stores each one in a receive queue. When the last bit has been shifted, the engine clears the start bit. Software polls that bit to learn that the exchange has finished, then reads the received bytes back one at a time.

The serial clock rate is set outside the block. An external rate generator supplies a one-cycle tick, and each tick marks one half-period of the serial clock. Clock polarity and phase are selected in the control word. One of four chip-select lines is chosen there too. The engine can drive the selected line for the whole exchange, or software can force it to a level of its own. Enable, mode, chip-select and queue-clear controls all share that one control word.

Top module: `spi_fifo_master`

## Requirements
- R1: Offsets are fixed: 0x00 receive data, 0x04 transmit data, 0x08 control, 0x20 burst count, 0x24 transmit count, 0x28 queue status. Control bits read back as written: enable bit 0, master bit 1, phase bit 2, polarity bit 3, low-active chip-select bit 4, line select 13:12, manual select bit 16, manual level bit 17. Other control bits read 0. Both counts read back as their low 24 bits. After reset every register reads 0.
- R2: Writing control with bit 10 set starts an exchange when bits 0 and 1 are also set in that write, no exchange is running and the burst count is non-zero. Bit 10 then reads 1 until the last byte has been shifted, then 0. In any other case bit 10 reads 0 and the serial clock does not toggle.
- R3: An exchange shifts exactly burst-count bytes, most significant bit first. The serial clock idles at the polarity bit. With the phase bit clear, data is sampled on the leading clock edge and changed on the trailing edge. With the phase bit set, data is changed on the leading edge and sampled on the trailing edge.
- R4: Each byte captured during an exchange is appended to the receive queue. Status bits 6:0 give the receive queue fill, which equals the burst count after an exchange into an empty queue. Reading offset 0x00 returns the oldest byte in bits 7:0 and removes it.
- R5: When the transmit queue is empty at the moment a byte is due, the master shifts 0x00 for that byte.
- R6: Writing 1 to control bit 8 empties the transmit queue. Writing 1 to control bit 9 empties the receive queue. Both bits read back as 0.
- R7: Each queue holds 64 bytes. A transmit write to a full queue, or a received byte arriving at a full queue, is dropped and sets status bit 31. Bit 31 stays set until software writes 1 to it.
- R8: With manual select off, the selected line is active from the cycle after the start until one tick period after the final clock edge. Active means 0 if bit 4 is set and 1 if it is clear. Every other line is always inactive.
- R9: With bit 16 set, the selected line outputs the level of bit 17 directly. Every other line outputs the inactive level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle the access is strobed |
| rate_tick | input | 1 | Half-period tick from the external rate generator |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip-select lines, polarity set by control bit 4 |

## Verification
A wrong bit count or wrong byte count shows up first as a receive fill that differs from the burst count. It also leaves the start bit stuck at 1 or clearing early, and this is visible on the first poll after the exchange should have ended. A phase or polarity error in the shift logic corrupts the first bit of the first byte. The slave model detects that within one serial clock period, and the bytes read back from the receive queue confirm it. Queue pointer faults appear as misordered or missing bytes only once a queue wraps or fills. For that reason the sweep includes 63- and 64-byte exchanges, a 65th transmit write and a receive push into a full queue.

// File: rtl/spim_pkg.sv
package spim_pkg;
   localparam logic [5:0] ADDR_RXD   = 6'h00;
   localparam logic [5:0] ADDR_TXD   = 6'h04;
   localparam logic [5:0] ADDR_CTL   = 6'h08;
   localparam logic [5:0] ADDR_BURST = 6'h20;
   localparam logic [5:0] ADDR_XMIT  = 6'h24;
   localparam logic [5:0] ADDR_STAT  = 6'h28;

   localparam int B_EN    = 0;
   localparam int B_MS    = 1;
   localparam int B_CPHA  = 2;
   localparam int B_CPOL  = 3;
   localparam int B_CSLOW = 4;
   localparam int B_TXCLR = 8;
   localparam int B_RXCLR = 9;
   localparam int B_XCH   = 10;
   localparam int B_SEL0  = 12;
   localparam int B_MAN   = 16;
   localparam int B_MLVL  = 17;
   localparam int B_OVF   = 31;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_LEAD  = 2'd1,
      ENG_SHIFT = 2'd2,
      ENG_TAIL  = 2'd3
   } eng_state_e;

   typedef struct packed {
      logic       man_lvl;
      logic       man_en;
      logic [1:0] cs_sel;
      logic       cs_low;
      logic       cpol;
      logic       cpha;
      logic       master;
      logic       enable;
   } ctl_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 64
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             flush,
   input  logic                             push,
   input  logic [WIDTH-1:0]                 wdata,
   input  logic                             pop,
   output logic [WIDTH-1:0]                 rdata,
   output logic [$clog2(DEPTH+1)-1:0]       count,
   output logic                             full,
   output logic                             empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("spim_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("spim_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic             do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign rdata   = mem[rd_ptr];

   if (POW2) begin : g_wrap_natural
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_compare
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= wdata;
   end

   AST_FIFO_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R7
   AST_FIFO_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> $stable(count)); // R7
   AST_FIFO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !flush) |=> $stable(count)); // R4
endmodule

// File: rtl/spim_engine.sv
module spim_engine
   import spim_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic [CNT_W-1:0] count,
   input  logic             cfg_cpol,
   input  logic             cfg_cpha,
   input  logic [7:0]       tx_byte,
   input  logic             tx_empty,
   output logic             tx_pop,
   input  logic             miso,
   output logic             rx_push,
   output logic [7:0]       rx_byte,
   output logic             busy,
   output logic             sclk,
   output logic             mosi
);
   if (CNT_W < 1 || CNT_W > 31) begin : g_bad_cnt
      $error("spim_engine: CNT_W out of range");
   end

   eng_state_e       state;
   logic [CNT_W-1:0] remaining;
   logic [2:0]       bit_idx;
   logic             half, act, cpol_q, cpha_q, mosi_q;
   logic [7:0]       tx_sh, rx_sh, next_byte, rx_in;
   logic             shift_tick, byte_end, load_next, eff_cpha;

   assign shift_tick = tick && (state == ENG_SHIFT);
   assign byte_end   = shift_tick && half && (bit_idx == 3'd7);
   assign load_next  = byte_end && (remaining != CNT_W'(1));
   assign tx_pop     = (start || load_next) && !tx_empty;
   assign next_byte  = tx_empty ? 8'h00 : tx_byte;
   assign rx_in      = {rx_sh[6:0], miso};
   assign rx_push    = byte_end;
   assign rx_byte    = cpha_q ? rx_in : rx_sh;
   assign busy       = (state != ENG_IDLE);
   assign sclk       = cpol_q ^ act;
   assign mosi       = mosi_q;
   assign eff_cpha   = (state == ENG_IDLE) ? cfg_cpha : cpha_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ENG_IDLE;
         remaining <= '0;
         bit_idx   <= '0;
         half      <= 1'b0;
         act       <= 1'b0;
         cpol_q    <= 1'b0;
         cpha_q    <= 1'b0;
         mosi_q    <= 1'b0;
         tx_sh     <= '0;
         rx_sh     <= '0;
      end else begin
         unique case (state)
            ENG_IDLE: begin
               if (start) begin
                  remaining <= count;
                  bit_idx   <= '0;
                  half      <= 1'b0;
                  act       <= 1'b0;
                  cpol_q    <= cfg_cpol;
                  cpha_q    <= cfg_cpha;
                  if (!eff_cpha) begin
                     mosi_q <= next_byte[7];
                     tx_sh  <= {next_byte[6:0], 1'b0};
                  end else begin
                     tx_sh  <= next_byte;
                  end
                  state <= ENG_LEAD;
               end
            end
            ENG_LEAD: begin
               if (tick) state <= ENG_SHIFT;
            end
            ENG_SHIFT: begin
               if (tick) begin
                  if (!half) begin
                     act  <= 1'b1;
                     half <= 1'b1;
                     if (!cpha_q) begin
                        rx_sh <= rx_in;
                     end else begin
                        mosi_q <= tx_sh[7];
                        tx_sh  <= {tx_sh[6:0], 1'b0};
                     end
                  end else begin
                     act  <= 1'b0;
                     half <= 1'b0;
                     if (cpha_q) rx_sh <= rx_in;
                     if (bit_idx == 3'd7) begin
                        bit_idx   <= '0;
                        remaining <= remaining - 1'b1;
                        if (remaining == CNT_W'(1)) begin
                           state <= ENG_TAIL;
                        end else if (!cpha_q) begin
                           mosi_q <= next_byte[7];
                           tx_sh  <= {next_byte[6:0], 1'b0};
                        end else begin
                           tx_sh  <= next_byte;
                        end
                     end else begin
                        bit_idx <= bit_idx + 1'b1;
                        if (!cpha_q) begin
                           mosi_q <= tx_sh[7];
                           tx_sh  <= {tx_sh[6:0], 1'b0};
                        end
                     end
                  end
               end
            end
            ENG_TAIL: begin
               if (tick) state <= ENG_IDLE;
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end

   AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)); // R2
   AST_ACT_ONLY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ENG_SHIFT) |-> !act); // R3
   AST_REMAIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ENG_SHIFT) |-> (remaining != '0)); // R3
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
   import spim_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int NUM_CS = 4,
   parameter int CNT_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [5:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              rate_tick,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [NUM_CS-1:0] spi_cs
);
   localparam int CW = $clog2(DEPTH + 1);

   if (NUM_CS < 1 || NUM_CS > 4) begin : g_bad_cs
      $error("spi_fifo_master: NUM_CS must be 1 to 4");
   end
   if (CW > 24) begin : g_bad_fill
      $error("spi_fifo_master: DEPTH too large for the status field");
   end
   if (CNT_W < 1 || CNT_W > 24) begin : g_bad_cntw
      $error("spi_fifo_master: CNT_W must be 1 to 24");
   end

   ctl_t             ctl_q;
   logic [CNT_W-1:0] burst_q, xmit_q;
   logic             ovf_q;

   logic wr_hit, wr_ctl, wr_txd, wr_stat, wr_burst, wr_xmit, rd_rxd;
   logic eng_start, eng_busy, eng_sclk, eng_tx_pop, eng_rx_push;
   logic eff_cpol, eff_cpha;
   logic [7:0] tx_head, rx_head, eng_rx_byte;
   logic [CW-1:0] tx_cnt, rx_cnt;
   logic tx_full, tx_empty, rx_full, rx_empty;
   logic ovf_set, ovf_clr;
   logic [31:0] ctl_rd;

   assign wr_hit   = bus_sel & bus_wr;
   assign wr_ctl   = wr_hit & (bus_addr == ADDR_CTL);
   assign wr_txd   = wr_hit & (bus_addr == ADDR_TXD);
   assign wr_stat  = wr_hit & (bus_addr == ADDR_STAT);
   assign wr_burst = wr_hit & (bus_addr == ADDR_BURST);
   assign wr_xmit  = wr_hit & (bus_addr == ADDR_XMIT);
   assign rd_rxd   = bus_sel & ~bus_wr & (bus_addr == ADDR_RXD);

   assign eng_start = wr_ctl & bus_wdata[B_XCH] & bus_wdata[B_EN] & bus_wdata[B_MS]
                      & ~eng_busy & (burst_q != '0);
   assign eff_cpol  = wr_ctl ? bus_wdata[B_CPOL] : ctl_q.cpol;
   assign eff_cpha  = wr_ctl ? bus_wdata[B_CPHA] : ctl_q.cpha;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         burst_q <= '0;
         xmit_q  <= '0;
      end else begin
         if (wr_ctl) begin
            ctl_q.enable  <= bus_wdata[B_EN];
            ctl_q.master  <= bus_wdata[B_MS];
            ctl_q.cpha    <= bus_wdata[B_CPHA];
            ctl_q.cpol    <= bus_wdata[B_CPOL];
            ctl_q.cs_low  <= bus_wdata[B_CSLOW];
            ctl_q.cs_sel  <= bus_wdata[B_SEL0 +: 2];
            ctl_q.man_en  <= bus_wdata[B_MAN];
            ctl_q.man_lvl <= bus_wdata[B_MLVL];
         end
         if (wr_burst) burst_q <= bus_wdata[CNT_W-1:0];
         if (wr_xmit)  xmit_q  <= bus_wdata[CNT_W-1:0];
      end
   end

   assign ovf_set = (wr_txd & tx_full) | (eng_rx_push & rx_full);
   assign ovf_clr = wr_stat & bus_wdata[B_OVF];

   always_ff @(posedge clk) begin
      if (!rst_n)       ovf_q <= 1'b0;
      else if (ovf_set) ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
   end

   spim_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .flush(wr_ctl & bus_wdata[B_TXCLR]),
      .push(wr_txd), .wdata(bus_wdata[7:0]),
      .pop(eng_tx_pop), .rdata(tx_head),
      .count(tx_cnt), .full(tx_full), .empty(tx_empty)
   );

   spim_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .flush(wr_ctl & bus_wdata[B_RXCLR]),
      .push(eng_rx_push), .wdata(eng_rx_byte),
      .pop(rd_rxd), .rdata(rx_head),
      .count(rx_cnt), .full(rx_full), .empty(rx_empty)
   );

   spim_engine #(.CNT_W(CNT_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .tick(rate_tick),
      .start(eng_start), .count(burst_q),
      .cfg_cpol(eff_cpol), .cfg_cpha(eff_cpha),
      .tx_byte(tx_head), .tx_empty(tx_empty), .tx_pop(eng_tx_pop),
      .miso(spi_miso), .rx_push(eng_rx_push), .rx_byte(eng_rx_byte),
      .busy(eng_busy), .sclk(eng_sclk), .mosi(spi_mosi)
   );

   assign spi_sclk = eng_busy ? eng_sclk : ctl_q.cpol;

   for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
      always_comb begin
         if (ctl_q.cs_sel == 2'(gi)) begin
            if (ctl_q.man_en)  spi_cs[gi] = ctl_q.man_lvl;
            else if (eng_busy) spi_cs[gi] = ~ctl_q.cs_low;
            else               spi_cs[gi] = ctl_q.cs_low;
         end else begin
            spi_cs[gi] = ctl_q.cs_low;
         end
      end
   end

   always_comb begin
      ctl_rd              = '0;
      ctl_rd[B_EN]        = ctl_q.enable;
      ctl_rd[B_MS]        = ctl_q.master;
      ctl_rd[B_CPHA]      = ctl_q.cpha;
      ctl_rd[B_CPOL]      = ctl_q.cpol;
      ctl_rd[B_CSLOW]     = ctl_q.cs_low;
      ctl_rd[B_XCH]       = eng_busy;
      ctl_rd[B_SEL0 +: 2] = ctl_q.cs_sel;
      ctl_rd[B_MAN]       = ctl_q.man_en;
      ctl_rd[B_MLVL]      = ctl_q.man_lvl;
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_RXD:   bus_rdata = {24'h0, rx_head};
         ADDR_CTL:   bus_rdata = ctl_rd;
         ADDR_BURST: bus_rdata = 32'(burst_q);
         ADDR_XMIT:  bus_rdata = 32'(xmit_q);
         ADDR_STAT:  bus_rdata = {ovf_q, (31 - CW)'(0), rx_cnt};
         default:    bus_rdata = '0;
      endcase
   end

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !ovf_clr) |=> ovf_q); // R7
   AST_CS_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_busy && !ctl_q.man_en) |-> (spi_cs == {NUM_CS{ctl_q.cs_low}})); // R8
   AST_SCLK_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_busy && $past(!eng_busy) && $stable(ctl_q.cpol)) |-> $stable(spi_sclk)); // R3
endmodule

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb;
   localparam logic [5:0] A_RXD = 6'h00, A_TXD = 6'h04, A_CTL = 6'h08;
   localparam logic [5:0] A_BUR = 6'h20, A_XMT = 6'h24, A_STA = 6'h28;
   localparam logic [31:0] EN = 32'h1, MS = 32'h2, XCH = 32'h400;
   localparam logic [31:0] TXCLR = 32'h100, RXCLR = 32'h200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_sel = 1'b0, bus_wr = 1'b0;
   logic [5:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic rate_tick;
   logic spi_sclk, spi_mosi;
   logic spi_miso;
   logic [3:0] spi_cs;

   int errors = 0, checks = 0;
   int cyc = 0;
   logic [1:0] tcnt = '0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc  <= cyc + 1;
      tcnt <= tcnt + 1'b1;
   end
   assign rate_tick = (tcnt == 2'd3);

   spi_fifo_master u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rate_tick(rate_tick), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .spi_cs(spi_cs)
   );

   // slave model configuration
   int   cur_mode = 0;
   logic cur_cpol = 0, cur_cpha = 0, cur_low = 0;
   logic [1:0] cur_sel = 0;
   logic [7:0] s_rx [0:79];
   int   bitc = 0, byte_i = 0, edge_cnt = 0;
   int   last_edge_cyc = 0, cs_off_cyc = 0;
   logic cs_prev = 0, sclk_prev = 0, cs_now, lead;
   logic [7:0] sh_in = 0, tmpb;

   function automatic logic [7:0] slv_byte(input int i);
      return 8'((i * 29 + 90 + cur_mode * 3) & 255);
   endfunction

   function automatic logic [7:0] mst_byte(input int i, input int salt);
      return 8'((i * 13 + 49 + salt * 5) & 255);
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         spi_miso = 1'b0;
         cs_prev = 1'b0;
         sclk_prev = spi_sclk;
      end else begin
         cs_now = (spi_cs[cur_sel] == ~cur_low);
         if (spi_sclk != sclk_prev) edge_cnt++;
         if (cs_now && !cs_prev) begin
            bitc = 0; byte_i = 0; sh_in = 0;
            if (!cur_cpha) begin
               tmpb = slv_byte(0);
               spi_miso = tmpb[7];
            end
         end
         if (!cs_now && cs_prev) cs_off_cyc = cyc;
         if (cs_now && (spi_sclk != sclk_prev)) begin
            lead = (spi_sclk != cur_cpol);
            last_edge_cyc = cyc;
            if (lead != cur_cpha) begin
               sh_in = {sh_in[6:0], spi_mosi};
               bitc++;
               if (bitc == 8) begin
                  if (byte_i < 80) s_rx[byte_i] = sh_in;
                  byte_i++;
                  bitc = 0;
               end
            end else begin
               tmpb = slv_byte(byte_i);
               spi_miso = tmpb[7 - bitc];
            end
         end
         cs_prev = cs_now;
         sclk_prev = spi_sclk;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   function automatic logic [3:0] cs_expect(input logic low, input logic [1:0] sel, input logic on);
      logic [3:0] v;
      v = {4{low}};
      if (on) v[sel] = ~low;
      return v;
   endfunction

   task automatic go(input logic [31:0] base, input int cnt);
      logic [31:0] d;
      int guard;
      wr(A_BUR, cnt);
      wr(A_XMT, cnt);
      cur_cpha = base[2]; cur_cpol = base[3]; cur_low = base[4]; cur_sel = base[13:12];
      for (int i = 0; i < 80; i++) s_rx[i] = 8'hEE;
      wr(A_CTL, base | XCH);
      rd(A_CTL, d);
      chk(d[10] == 1'b1, "R2 start bit held while running", d[10], 1);
      chk(spi_cs == cs_expect(cur_low, cur_sel, 1'b1), "R8 selected line active", spi_cs,
          cs_expect(cur_low, cur_sel, 1'b1));
      guard = 0;
      while (d[10] && guard < 30000) begin
         rd(A_CTL, d);
         guard++;
      end
      chk(d[10] == 1'b0, "R2 start bit clears at end", d[10], 0);
   endtask

   initial begin
      logic [31:0] d, base;
      int cnt, salt;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // reset state (R1)
      rd(A_CTL, d);  chk(d == 0, "R1 control after reset", d, 0);
      rd(A_STA, d);  chk(d == 0, "R1 status after reset", d, 0);
      rd(A_BUR, d);  chk(d == 0, "R1 burst after reset", d, 0);
      chk(spi_cs == 4'h0 && spi_sclk == 1'b0, "R1 pins after reset", {spi_cs, spi_sclk}, 0);

      // readback (R1)
      wr(A_CTL, 32'h0003_303F);
      rd(A_CTL, d);  chk(d == 32'h0003_301F, "R1 control readback", d, 32'h0003_301F);
      wr(A_BUR, 32'hFF12_3456);
      rd(A_BUR, d);  chk(d == 32'h0012_3456, "R1 burst readback", d, 32'h0012_3456);
      wr(A_XMT, 32'hAB00_0FED);
      rd(A_XMT, d);  chk(d == 32'h0000_0FED, "R1 transmit count readback", d, 32'h0000_0FED);

      // manual chip select (R9)
      wr(A_CTL, EN | MS | 32'h10 | 32'h2000 | 32'h1_0000 | 32'h2_0000);
      chk(spi_cs == 4'b1111, "R9 manual high, low-active", spi_cs, 4'b1111);
      wr(A_CTL, EN | MS | 32'h10 | 32'h2000 | 32'h1_0000);
      chk(spi_cs == 4'b1011, "R9 manual low, low-active", spi_cs, 4'b1011);
      wr(A_CTL, EN | MS | 32'h1000 | 32'h1_0000 | 32'h2_0000);
      chk(spi_cs == 4'b0010, "R9 manual high, high-active", spi_cs, 4'b0010);
      wr(A_CTL, EN | MS | 32'h1000 | 32'h1_0000);
      chk(spi_cs == 4'b0000, "R9 manual low, high-active", spi_cs, 4'b0000);

      // start ignored (R2)
      wr(A_CTL, MS | TXCLR | RXCLR);
      wr(A_BUR, 3);
      cnt = edge_cnt;
      wr(A_CTL, MS | XCH);
      rd(A_CTL, d);  chk(d[10] == 1'b0, "R2 start ignored while disabled", d[10], 0);
      repeat (40) @(negedge clk);
      chk(edge_cnt == cnt, "R2 no clock while disabled", edge_cnt, cnt);
      rd(A_STA, d);  chk(d[6:0] == 0, "R2 nothing received while disabled", d[6:0], 0);
      wr(A_BUR, 0);
      wr(A_CTL, EN | MS | XCH);
      rd(A_CTL, d);  chk(d[10] == 1'b0, "R2 zero count never starts", d[10], 0);

      // mode and length sweep (R3, R4, R8)
      for (int m = 0; m < 4; m++) begin
         for (int k = 0; k < 4; k++) begin
            cnt = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 7 : 63;
            salt = m * 4 + k;
            cur_mode = m;
            base = EN | MS | (m[0] ? 32'h4 : 32'h0) | (m[1] ? 32'h8 : 32'h0)
                   | (k[0] ? 32'h10 : 32'h0) | (32'((m + k) % 4) << 12);
            wr(A_CTL, base | TXCLR | RXCLR);
            for (int i = 0; i < cnt; i++) wr(A_TXD, {24'h0, mst_byte(i, salt)});
            go(base, cnt);
            for (int i = 0; i < cnt; i++)
               chk(s_rx[i] == mst_byte(i, salt), "R3 byte seen by slave", s_rx[i], mst_byte(i, salt));
            chk(spi_sclk == base[3], "R3 clock idles at polarity", spi_sclk, base[3]);
            chk(cs_off_cyc - last_edge_cyc == 4, "R8 release one half-period after last edge",
                cs_off_cyc - last_edge_cyc, 4);
            chk(spi_cs == {4{base[4]}}, "R8 all lines idle after exchange", spi_cs, {4{base[4]}});
            rd(A_STA, d);
            chk(d[6:0] == cnt, "R4 receive fill equals burst", d[6:0], cnt);
            for (int i = 0; i < cnt; i++) begin
               rd(A_RXD, d);
               chk(d[7:0] == slv_byte(i), "R4 received byte order", d[7:0], slv_byte(i));
            end
            rd(A_STA, d);
            chk(d[6:0] == 0, "R4 queue drained by reads", d[6:0], 0);
         end
      end

      // transmit queue runs dry (R5)
      cur_mode = 1;
      base = EN | MS | 32'h4 | 32'h10;
      wr(A_CTL, base | TXCLR | RXCLR);
      wr(A_TXD, 32'hC3);
      wr(A_TXD, 32'h81);
      go(base, 5);
      chk(s_rx[0] == 8'hC3 && s_rx[1] == 8'h81, "R5 queued bytes first", {s_rx[0], s_rx[1]}, 16'hC381);
      for (int i = 2; i < 5; i++) chk(s_rx[i] == 8'h00, "R5 zero fill when empty", s_rx[i], 0);

      // queue clears (R6)
      cur_mode = 0;
      base = EN | MS | 32'h10;
      wr(A_CTL, base | RXCLR);
      wr(A_TXD, 32'h11); wr(A_TXD, 32'h22); wr(A_TXD, 32'h33);
      wr(A_CTL, base | TXCLR);
      go(base, 2);
      chk(s_rx[0] == 8'h00 && s_rx[1] == 8'h00, "R6 transmit clear discards bytes",
          {s_rx[0], s_rx[1]}, 0);
      rd(A_CTL, d);  chk(d[9:8] == 2'b00, "R6 clear bits read zero", d[9:8], 0);
      rd(A_STA, d);  chk(d[6:0] == 2, "R6 receive holds two before clear", d[6:0], 2);
      wr(A_CTL, base | RXCLR);
      rd(A_STA, d);  chk(d[6:0] == 0, "R6 receive clear empties queue", d[6:0], 0);

      // overflow (R7)
      wr(A_CTL, base | TXCLR | RXCLR);
      for (int i = 0; i < 65; i++) wr(A_TXD, {24'h0, mst_byte(i, 7)});
      rd(A_STA, d);  chk(d[31] == 1'b1, "R7 transmit overflow sticky", d[31], 1);
      wr(A_STA, 32'h8000_0000);
      rd(A_STA, d);  chk(d[31] == 1'b0, "R7 overflow cleared by write", d[31], 0);
      go(base, 64);
      chk(s_rx[63] == mst_byte(63, 7), "R7 sixty-fourth byte kept", s_rx[63], mst_byte(63, 7));
      rd(A_STA, d);  chk(d == 32'd64, "R7 receive full without overflow", d, 64);
      go(base, 1);
      chk(s_rx[0] == 8'h00, "R7 sixty-fifth write was dropped", s_rx[0], 0);
      rd(A_STA, d);  chk(d == 32'h8000_0040, "R7 receive overflow sets flag", d, 32'h8000_0040);
      rd(A_RXD, d);  chk(d[7:0] == slv_byte(0), "R7 stored bytes untouched", d[7:0], slv_byte(0));

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 20);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule